// File: doc/BRIEF.md
# Output Compare Pin Action Logic

This block owns the output pin levels of a group of output compare channels that share one free-running 16-bit timer. For each channel it gathers every event that can move the pin in a given clock cycle: the compare-match pulse, a software-forced compare strobe, a counter-overflow toggle enabled per channel, and an override event issued by the master channel. It picks the one winner by a fixed priority and stores the resulting level in a per-channel flip-flop that drives the pin.

The surrounding timer supplies the overflow pulse, the per-channel compare-match pulses and the master-channel override pulse together with its mask and data. Its register file supplies the action fields, the toggle-on-overflow enables and the per-channel output-compare mode bits. A channel that is not in output compare mode ignores every event and holds its pin. The counter, input capture and bus decoding are outside this block.

Top module: `oc_pin_action`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every bit of `pin_out` is 0.
- R2: Each channel's action is a 2-bit field in `ctl_act`, with the mode bit as the upper bit. A compare match applies the action one clock later: 2'b01 inverts the pin, 2'b10 drives it to 0, 2'b11 drives it to 1, and 2'b00 leaves it unchanged.
- R3: A force strobe applies the same action as a compare match. When a force strobe and a match reach one channel in the same cycle, the action is applied once, so a toggle field inverts the pin only once.
- R4: When the channel's `tov_en` bit is set, a `cnt_ovf` pulse inverts the pin one clock later.
- R5: When `tov_en` is 0, `cnt_ovf` has no effect on the pin.
- R6: An overflow toggle that occurs in the same cycle as a force strobe or a compare match wins over both. The pin is inverted and the action field is not applied.
- R7: An override event (`ovr_evt` high with the channel's `ovr_mask` bit set) loads that channel's `ovr_data` bit into the pin one clock later. It wins over an overflow toggle, a force strobe and a compare match.
- R8: A channel whose `oc_mode` bit is 0 holds its pin whatever events arrive, including overflow with `tov_en` set.
- R9: Channel i takes its action field from bits [2i+1:2i] of `ctl_act`, so the field of the highest channel sits in the most significant bits. The channels act independently within one cycle.
- R10: An override event leaves channels whose `ovr_mask` bit is 0 to the lower-priority events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_mode | input | NCH | Per-channel output compare mode enable |
| ctl_act | input | 2*NCH | Packed action fields, channel i at [2i+1:2i] |
| tov_en | input | NCH | Per-channel toggle-on-overflow enable |
| cmp_match | input | NCH | Per-channel compare-match pulse |
| frc_stb | input | NCH | Per-channel forced-compare strobe |
| ovr_evt | input | 1 | Master-channel override event pulse |
| ovr_mask | input | NCH | Channels affected by the override |
| ovr_data | input | NCH | Levels loaded by the override |
| cnt_ovf | input | 1 | Timer counter overflow pulse |
| pin_out | output | NCH | Registered pin levels |

## Verification
Every event reaches `pin_out` exactly one clock after the cycle in which it is presented, because only the pin flip-flop lies between the inputs and the pins. The bench drives each stimulus just after a rising edge. It advances its behavioural reference model by one step per clock and compares all pins one time unit after the next rising edge, when the registered value has settled. Collision cases put two events into that same single cycle, so the check a clock later shows which event won.

// File: rtl/oc_pin_pkg.sv
package oc_pin_pkg;

    // Per-channel action field; upper bit selects "drive level", lower bit is level/toggle.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    // Winning event source, in descending priority below EV_IDLE.
    typedef enum logic [2:0] {
        EV_IDLE     = 3'd0,
        EV_OVERRIDE = 3'd1,
        EV_OVF_TGL  = 3'd2,
        EV_FORCE    = 3'd3,
        EV_MATCH    = 3'd4
    } oc_src_e;

    // Events seen by one channel in one cycle.
    typedef struct packed {
        logic    chan_on;
        oc_act_e act;
        logic    tov_on;
        logic    match;
        logic    frc;
        logic    ovr_hit;
        logic    ovr_val;
        logic    ovf;
    } oc_chan_ev_t;

    // Arbitration result for one channel.
    typedef struct packed {
        oc_src_e src;
        logic    upd;
        logic    val;
    } oc_decision_t;

    function automatic logic act_apply(oc_act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

    function automatic oc_src_e pick_source(oc_chan_ev_t ev);
        if (!ev.chan_on)              return EV_IDLE;
        else if (ev.ovr_hit)          return EV_OVERRIDE;
        else if (ev.ovf && ev.tov_on) return EV_OVF_TGL;
        else if (ev.frc)              return EV_FORCE;
        else if (ev.match)            return EV_MATCH;
        else                          return EV_IDLE;
    endfunction

endpackage

// File: rtl/oc_field_unpack.sv
module oc_field_unpack
    import oc_pin_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [2*NCH-1:0]  fields,
    output oc_act_e [NCH-1:0] acts
);
    localparam int FW = 2;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign acts[g] = oc_act_e'(fields[g*FW +: FW]);
    end

endmodule

// File: rtl/oc_chan_arbiter.sv
module oc_chan_arbiter
    import oc_pin_pkg::*;
(
    input  oc_chan_ev_t  ev,
    input  logic         cur,
    output oc_decision_t dec
);
    oc_src_e src;

    always_comb begin
        src     = pick_source(ev);
        dec.src = src;
        dec.upd = (src != EV_IDLE);
        case (src)
            EV_OVERRIDE: dec.val = ev.ovr_val;
            EV_OVF_TGL:  dec.val = ~cur;
            EV_FORCE,
            EV_MATCH:    dec.val = act_apply(ev.act, cur);
            default:     dec.val = cur;
        endcase
    end

endmodule

// File: rtl/oc_pin_bank.sv
module oc_pin_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] upd,
    input  logic [NCH-1:0] val,
    output logic [NCH-1:0] pins
);
    for (genvar g = 0; g < NCH; g++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst) begin
                pins[g] <= 1'b0;
            end else if (upd[g]) begin
                pins[g] <= val[g];
            end
        end
    end

endmodule

// File: rtl/oc_pin_action.sv
module oc_pin_action
    import oc_pin_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   oc_mode,
    input  logic [2*NCH-1:0] ctl_act,
    input  logic [NCH-1:0]   tov_en,
    input  logic [NCH-1:0]   cmp_match,
    input  logic [NCH-1:0]   frc_stb,
    input  logic             ovr_evt,
    input  logic [NCH-1:0]   ovr_mask,
    input  logic [NCH-1:0]   ovr_data,
    input  logic             cnt_ovf,
    output logic [NCH-1:0]   pin_out
);
    oc_act_e [NCH-1:0] acts;
    logic    [NCH-1:0] upd;
    logic    [NCH-1:0] val;

    oc_field_unpack #(.NCH(NCH)) u_unpack (
        .fields (ctl_act),
        .acts   (acts)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_arb
        oc_chan_ev_t  ev;
        oc_decision_t dec;

        always_comb begin
            ev.chan_on = oc_mode[g];
            ev.act     = acts[g];
            ev.tov_on  = tov_en[g];
            ev.match   = cmp_match[g];
            ev.frc     = frc_stb[g];
            ev.ovr_hit = ovr_evt & ovr_mask[g];
            ev.ovr_val = ovr_data[g];
            ev.ovf     = cnt_ovf;
        end

        oc_chan_arbiter u_arb (
            .ev  (ev),
            .cur (pin_out[g]),
            .dec (dec)
        );

        assign upd[g] = dec.upd;
        assign val[g] = dec.val;
    end

    oc_pin_bank #(.NCH(NCH)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .val  (val),
        .pins (pin_out)
    );

endmodule

// File: rtl/oc_pin_action_chk.sv
module oc_pin_action_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   oc_mode,
    input logic [2*NCH-1:0] ctl_act,
    input logic [NCH-1:0]   tov_en,
    input logic [NCH-1:0]   cmp_match,
    input logic [NCH-1:0]   frc_stb,
    input logic             ovr_evt,
    input logic [NCH-1:0]   ovr_mask,
    input logic [NCH-1:0]   ovr_data,
    input logic             cnt_ovf,
    input logic [NCH-1:0]   pin_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R7
        ovr_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (oc_mode[i] && ovr_evt && ovr_mask[i]) |=> (pin_out[i] == $past(ovr_data[i])));

        // R6
        ovf_toggle_chk: assert property (@(posedge clk) disable iff (rst)
            (oc_mode[i] && !(ovr_evt && ovr_mask[i]) && cnt_ovf && tov_en[i])
            |=> (pin_out[i] != $past(pin_out[i])));

        // R8
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !oc_mode[i] |=> $stable(pin_out[i]));

        // R2
        clear_act_chk: assert property (@(posedge clk) disable iff (rst)
            (oc_mode[i] && !(ovr_evt && ovr_mask[i]) && !(cnt_ovf && tov_en[i])
             && (cmp_match[i] || frc_stb[i]) && ctl_act[2*i+1 -: 2] == 2'b10)
            |=> !pin_out[i]);

        // R5
        no_event_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!(ovr_evt && ovr_mask[i]) && !(cnt_ovf && tov_en[i])
             && !cmp_match[i] && !frc_stb[i]) |=> $stable(pin_out[i]));
    end

endmodule

bind oc_pin_action oc_pin_action_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/oc_pin_action_bench.sv
`timescale 1ns/1ps
module oc_pin_action_bench;
    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH-1:0]   oc_mode = '0;
    logic [2*NCH-1:0] ctl_act = '0;
    logic [NCH-1:0]   tov_en = '0;
    logic [NCH-1:0]   cmp_match = '0;
    logic [NCH-1:0]   frc_stb = '0;
    logic             ovr_evt = 1'b0;
    logic [NCH-1:0]   ovr_mask = '0;
    logic [NCH-1:0]   ovr_data = '0;
    logic             cnt_ovf = 1'b0;
    logic [NCH-1:0]   pin_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [NCH-1:0] exp_pin = '0;

    always #2.5 clk = ~clk;

    oc_pin_action #(.NCH(NCH)) u_oc_pin_action (.*);

    // Behavioural reference: one step of the priority rules.
    function automatic logic [NCH-1:0] model_step(logic [NCH-1:0] now);
        logic [NCH-1:0] nxt;
        nxt = now;
        for (int c = 0; c < NCH; c++) begin
            logic [1:0] f;
            f = ctl_act[2*c +: 2];
            if (!oc_mode[c]) continue;
            if (ovr_evt && ovr_mask[c])          nxt[c] = ovr_data[c];
            else if (cnt_ovf && tov_en[c])       nxt[c] = ~now[c];
            else if (frc_stb[c] || cmp_match[c]) begin
                if (f == 2'b01)      nxt[c] = ~now[c];
                else if (f == 2'b10) nxt[c] = 1'b0;
                else if (f == 2'b11) nxt[c] = 1'b1;
            end
        end
        return nxt;
    endfunction

    task automatic check(string tag, logic [NCH-1:0] got, logic [NCH-1:0] want);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: pin_out=%b expected=%b at %0t", tag, got, want, $time);
        end
    endtask

    task automatic quiet;
        cmp_match = '0; frc_stb = '0; ovr_evt = 1'b0;
        ovr_mask = '0;  ovr_data = '0; cnt_ovf = 1'b0;
    endtask

    task automatic tick(string tag);
        exp_pin = model_step(exp_pin);
        @(posedge clk);
        #1;
        check(tag, pin_out, exp_pin);
        quiet();
    endtask

    task automatic set_act(int ch, logic [1:0] code);
        ctl_act[2*ch +: 2] = code;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: pin_out=%b expected=run end", pin_out);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", pin_out, '0);
        rst = 1'b0;
        exp_pin = '0;
        // R1: first cycle after reset still low
        tick("R1");

        oc_mode = '1;
        // R2: each encoding via match on channel 0
        set_act(0, 2'b11); cmp_match = 4'b0001; tick("R2");
        set_act(0, 2'b00); cmp_match = 4'b0001; tick("R2");
        set_act(0, 2'b10); cmp_match = 4'b0001; tick("R2");
        set_act(0, 2'b01); cmp_match = 4'b0001; tick("R2");
        cmp_match = 4'b0001; tick("R2");
        set_act(0, 2'b00); cmp_match = 4'b0001; tick("R2");

        // R3: force applies action; force+match toggles once
        set_act(0, 2'b01); frc_stb = 4'b0001; tick("R3");
        frc_stb = 4'b0001; cmp_match = 4'b0001; tick("R3");
        set_act(0, 2'b11); frc_stb = 4'b0001; cmp_match = 4'b0001; tick("R3");

        // R4: overflow toggle enabled on channel 1
        tov_en = 4'b0010; cnt_ovf = 1'b1; tick("R4");
        cnt_ovf = 1'b1; tick("R4");
        cnt_ovf = 1'b1; tick("R4");

        // R5: enable off -> no effect
        tov_en = 4'b0000; cnt_ovf = 1'b1; tick("R5");

        // R6: overflow beats force and match on channel 2
        tov_en = 4'b0100; set_act(2, 2'b11);
        cnt_ovf = 1'b1; frc_stb = 4'b0100; tick("R6");
        cnt_ovf = 1'b1; cmp_match = 4'b0100; tick("R6");
        set_act(2, 2'b10);
        cnt_ovf = 1'b1; frc_stb = 4'b0100; cmp_match = 4'b0100; tick("R6");

        // R7: override beats overflow, force and match on channel 2
        ovr_evt = 1'b1; ovr_mask = 4'b0100; ovr_data = 4'b0000; cnt_ovf = 1'b1; tick("R7");
        set_act(2, 2'b10);
        ovr_evt = 1'b1; ovr_mask = 4'b0100; ovr_data = 4'b0100; frc_stb = 4'b0100; tick("R7");
        ovr_evt = 1'b1; ovr_mask = 4'b0100; ovr_data = 4'b0100; cmp_match = 4'b0100; tick("R7");
        set_act(2, 2'b11);
        ovr_evt = 1'b1; ovr_mask = 4'b0100; ovr_data = 4'b0000;
        cnt_ovf = 1'b1; frc_stb = 4'b0100; cmp_match = 4'b0100; tick("R7");

        // R10: unmasked channels fall through to lower priority
        set_act(3, 2'b11); set_act(1, 2'b10);
        ovr_evt = 1'b1; ovr_mask = 4'b0001; ovr_data = 4'b0000;
        cmp_match = 4'b1010; tick("R10");
        ovr_evt = 1'b1; ovr_mask = 4'b1000; ovr_data = 4'b0111; frc_stb = 4'b0001; tick("R10");

        // R9: per-channel fields, all channels at once
        set_act(0, 2'b11); set_act(1, 2'b01); set_act(2, 2'b10); set_act(3, 2'b00);
        tov_en = '0; cmp_match = 4'b1111; tick("R9");
        cmp_match = 4'b1111; tick("R9");
        ctl_act = 8'b01_11_10_01; frc_stb = 4'b1111; tick("R9");

        // R8: channels out of OC mode ignore everything
        oc_mode = 4'b0101; tov_en = '1; ctl_act = 8'b01_01_01_01;
        cnt_ovf = 1'b1; tick("R8");
        ovr_evt = 1'b1; ovr_mask = '1; ovr_data = ~pin_out; tick("R8");
        frc_stb = '1; cmp_match = '1; cnt_ovf = 1'b1; tick("R8");

        // Mixed random traffic against the model
        for (int k = 0; k < 400; k++) begin
            oc_mode   = NCH'($urandom);
            ctl_act   = (2*NCH)'($urandom);
            tov_en    = NCH'($urandom);
            cmp_match = NCH'($urandom);
            frc_stb   = NCH'($urandom);
            ovr_evt   = 1'($urandom);
            ovr_mask  = NCH'($urandom);
            ovr_data  = NCH'($urandom);
            cnt_ovf   = 1'($urandom);
            tick("R6/R7/R9 mixed");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule